// File: doc/BRIEF.md
# External data bus cycle sequencer

This block carries out the external data memory transfer of an 8051-style microcontroller core, the two-machine-cycle access used by the move-external instructions. It has its own machine-cycle phase counter. One machine cycle is six states of two phases each, so the counter walks through twelve slots, S1P1 to S6P2, and the current slot is brought out so the rest of the core can stay aligned to it.

To start an access, pulse `start` together with a direction, an address mode and the operands. The address mode is either an 8-bit register-indirect address or a 16-bit pointer. The sequencer takes the operands only while it is idle. The access always opens at the next S1P1. Every bus edge is tied to a fixed slot of the first or second machine cycle:

- the bus request;
- the address latch enable (ALE);
- the address and data drivers on the multiplexed low port;
- the high address port;
- the active-low read and write strobes, each with its own drive enable.

A read returns the captured byte with a one-cycle done pulse. A write gets the same done pulse.

Slot indices are numbered S1P1=0, S1P2=1, and so on up to S6P2=11. The first machine cycle of an access is called C1 and the second C2.

Top module: `xbus_seq`

## Requirements
- R1: `phase` advances by one slot per clock from 0 to 11 and wraps from 11 to 0.
- R2: A `start` sampled while an access is pending or running is ignored. An accepted access begins at the first S1P1 (phase 0) entered after the accepting edge. A `start` sampled during phase 11 therefore begins on the very next clock, and a `start` during the done slot is accepted.
- R3: On entry to C1 S1P1 the low port output value becomes all ones (0xFF), with `lo_oe` still low.
- R4: `bus_req` is high from C1 S3P1 (phase 4) through C2 S3P2 (phase 5).
- R5: `ale` is high only in C1 S4P2 and C1 S5P1 (phases 7 and 8). It rises at phase 7 and falls at phase 9.
- R6: From C1 S5P1 on, the multiplexed port carries the low address byte with `lo_oe` high. In 16-bit mode (`mode_wide`=1), `hi_out` carries the high address byte with `hi_oe` high. In 8-bit mode, `hi_oe` stays low and `hi_out` keeps its value.
- R7: For a read (`dir_wr`=0), `rd_n` is low from C2 S1P1 through C2 S3P2. `lo_oe` drops at C2 S1P1. The byte on `lo_in` during C2 S3P1 appears on `rdata` at C2 S4P1.
- R8: For a write (`dir_wr`=1), `lo_out` changes to the write byte at C1 S6P2. `wr_n` is low from C2 S1P1 through C2 S3P2.
- R9: At C2 S4P1 (phase 6), `done` is high for exactly one clock. In the same cycle `bus_req`, `lo_oe`, `hi_oe`, `rd_oe` and `wr_oe` are all low.
- R10: Only the strobe for the active direction is enabled. `rd_oe` is high only during reads and `wr_oe` only during writes, from C1 S5P1 to C2 S4P1 (exclusive).
- R11: Synchronous reset sets `phase` to 0, `rd_n` and `wr_n` high, and `ale`, `bus_req`, `done` and every drive enable low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Phase clock, one slot per cycle |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request an access; taken only while idle |
| dir_wr | input | 1 | 1 = write, 0 = read |
| mode_wide | input | 1 | 1 = 16-bit pointer address, 0 = 8-bit register-indirect |
| addr | input | ADDR_W | Access address |
| wdata | input | DATA_W | Byte to write |
| lo_in | input | DATA_W | Multiplexed low port input |
| phase | output | 4 | Current slot, 0 (S1P1) to 11 (S6P2) |
| lo_out | output | DATA_W | Multiplexed low port output value |
| lo_oe | output | 1 | Low port drive enable |
| hi_out | output | ADDR_W-DATA_W | High address port value |
| hi_oe | output | 1 | High address port drive enable |
| ale | output | 1 | Address latch enable |
| bus_req | output | 1 | External bus claimed |
| rd_n | output | 1 | Read strobe, active low |
| rd_oe | output | 1 | Read strobe drive enable |
| wr_n | output | 1 | Write strobe, active low |
| wr_oe | output | 1 | Write strobe drive enable |
| rdata | output | DATA_W | Captured read byte |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the block with its default parameters: an 8-bit data byte and a 16-bit address, giving an 8-bit high port. These values let each of the four direction and mode combinations be compared slot by slot against a behavioural model. They also cover the start-in-phase-11 and start-in-done-slot corners. The bench holds `lo_in` at a decoy value except in C2 S3P1, so a capture in any other slot shows up as a wrong `rdata`.

// File: rtl/xbus_pkg.sv
package xbus_pkg;
  localparam int unsigned PHASES_PER_STATE = 2;
  localparam int unsigned STATES_PER_CYCLE = 6;
  localparam int unsigned SLOTS  = PHASES_PER_STATE * STATES_PER_CYCLE;
  localparam int unsigned SLOT_W = $clog2(SLOTS);

  typedef logic [SLOT_W-1:0] slot_t;

  typedef enum logic [1:0] {
    SQ_IDLE,
    SQ_ARMED,
    SQ_FIRST,
    SQ_SECOND
  } seq_t;

  // Slot index of a named state (1..6) and phase (1..2).
  function automatic slot_t slot_of(int unsigned st, int unsigned ph);
    return slot_t'((st - 1) * PHASES_PER_STATE + (ph - 1));
  endfunction

  // Slot that follows s, wrapping at the end of a machine cycle.
  function automatic slot_t slot_after(slot_t s);
    return (s == slot_t'(SLOTS - 1)) ? slot_t'(0) : slot_t'(s + 1'b1);
  endfunction

  localparam slot_t SL_S1P1 = slot_of(1, 1);
  localparam slot_t SL_S3P1 = slot_of(3, 1);
  localparam slot_t SL_S4P1 = slot_of(4, 1);
  localparam slot_t SL_S4P2 = slot_of(4, 2);
  localparam slot_t SL_S5P1 = slot_of(5, 1);
  localparam slot_t SL_S5P2 = slot_of(5, 2);
  localparam slot_t SL_S6P2 = slot_of(6, 2);
endpackage

// File: rtl/xbus_phase_ctr.sv
module xbus_phase_ctr
  import xbus_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  output slot_t slot,
  output slot_t slot_nxt
);
  assign slot_nxt = slot_after(slot);

  always_ff @(posedge clk) begin
    if (rst) slot <= SL_S1P1;
    else     slot <= slot_nxt;
  end
endmodule

// File: rtl/xbus_seq_ctrl.sv
module xbus_seq_ctrl
  import xbus_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  start,
  input  slot_t slot,
  input  slot_t slot_nxt,
  output logic  accept,
  output logic  ev_load,
  output logic  ev_req_on,
  output logic  ev_ale_on,
  output logic  ev_addr,
  output logic  ev_ale_off,
  output logic  ev_data,
  output logic  ev_strobe,
  output logic  ev_capture,
  output logic  ev_end
);
  seq_t st, st_nxt;
  logic in_first, in_second;

  assign accept = (st == SQ_IDLE) && start;

  always_comb begin
    st_nxt = st;
    unique case (st)
      SQ_IDLE:   if (start) st_nxt = (slot_nxt == SL_S1P1) ? SQ_FIRST : SQ_ARMED;
      SQ_ARMED:  if (slot_nxt == SL_S1P1) st_nxt = SQ_FIRST;
      SQ_FIRST:  if (slot_nxt == SL_S1P1) st_nxt = SQ_SECOND;
      SQ_SECOND: if (slot_nxt == SL_S4P1) st_nxt = SQ_IDLE;
      default:   st_nxt = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) st <= SQ_IDLE;
    else     st <= st_nxt;
  end

  // Events fire on the edge that enters the named slot.
  assign in_first   = (st_nxt == SQ_FIRST);
  assign in_second  = (st_nxt == SQ_SECOND);
  assign ev_load    = in_first  && (slot_nxt == SL_S1P1);
  assign ev_req_on  = in_first  && (slot_nxt == SL_S3P1);
  assign ev_ale_on  = in_first  && (slot_nxt == SL_S4P2);
  assign ev_addr    = in_first  && (slot_nxt == SL_S5P1);
  assign ev_ale_off = in_first  && (slot_nxt == SL_S5P2);
  assign ev_data    = in_first  && (slot_nxt == SL_S6P2);
  assign ev_strobe  = in_second && (slot_nxt == SL_S1P1);
  // Capture samples during S3P1 itself; end fires entering S4P1.
  assign ev_capture = (st == SQ_SECOND) && (slot == SL_S3P1);
  assign ev_end     = (st == SQ_SECOND) && (slot_nxt == SL_S4P1);
endmodule

// File: rtl/xbus_port_drv.sv
module xbus_port_drv #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 16,
  localparam int unsigned HI_W  = ADDR_W - DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  logic              dir_wr,
  input  logic              mode_wide,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] lo_in,
  input  logic              ev_load,
  input  logic              ev_req_on,
  input  logic              ev_ale_on,
  input  logic              ev_addr,
  input  logic              ev_ale_off,
  input  logic              ev_data,
  input  logic              ev_strobe,
  input  logic              ev_capture,
  input  logic              ev_end,
  output logic [DATA_W-1:0] lo_out,
  output logic              lo_oe,
  output logic [HI_W-1:0]   hi_out,
  output logic              hi_oe,
  output logic              ale,
  output logic              bus_req,
  output logic              rd_n,
  output logic              rd_oe,
  output logic              wr_n,
  output logic              wr_oe,
  output logic [DATA_W-1:0] rdata,
  output logic              done
);
  logic              op_wr, op_wide;
  logic [ADDR_W-1:0] op_addr;
  logic [DATA_W-1:0] op_wdata;
  logic [DATA_W-1:0] cap;

  // Operands are held from acceptance so the caller may move on.
  always_ff @(posedge clk) begin
    if (rst) begin
      op_wr <= 1'b0; op_wide <= 1'b0; op_addr <= '0; op_wdata <= '0;
    end else if (accept) begin
      op_wr <= dir_wr; op_wide <= mode_wide; op_addr <= addr; op_wdata <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_out <= '0; lo_oe <= 1'b0; hi_out <= '0; hi_oe <= 1'b0;
      ale <= 1'b0; bus_req <= 1'b0;
      rd_n <= 1'b1; rd_oe <= 1'b0; wr_n <= 1'b1; wr_oe <= 1'b0;
      rdata <= '0; cap <= '0; done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (ev_load)    lo_out  <= '1;
      if (ev_req_on)  bus_req <= 1'b1;
      if (ev_ale_on)  ale     <= 1'b1;
      if (ev_ale_off) ale     <= 1'b0;
      if (ev_addr) begin
        lo_out <= op_addr[DATA_W-1:0];
        lo_oe  <= 1'b1;
        hi_oe  <= op_wide;
        if (op_wide) hi_out <= op_addr[ADDR_W-1:DATA_W];
        rd_oe  <= !op_wr;
        wr_oe  <= op_wr;
      end
      if (ev_data && op_wr) lo_out <= op_wdata;
      if (ev_strobe) begin
        if (op_wr) wr_n <= 1'b0;
        else begin
          rd_n  <= 1'b0;
          lo_oe <= 1'b0;
        end
      end
      if (ev_capture && !op_wr) cap <= lo_in;
      if (ev_end) begin
        rd_n <= 1'b1; wr_n <= 1'b1;
        bus_req <= 1'b0;
        lo_oe <= 1'b0; hi_oe <= 1'b0; rd_oe <= 1'b0; wr_oe <= 1'b0;
        done <= 1'b1;
        if (!op_wr) rdata <= cap;
      end
    end
  end
endmodule

// File: rtl/xbus_seq.sv
module xbus_seq
  import xbus_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 16,
  localparam int unsigned HI_W  = ADDR_W - DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              dir_wr,
  input  logic              mode_wide,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] lo_in,
  output logic [SLOT_W-1:0] phase,
  output logic [DATA_W-1:0] lo_out,
  output logic              lo_oe,
  output logic [HI_W-1:0]   hi_out,
  output logic              hi_oe,
  output logic              ale,
  output logic              bus_req,
  output logic              rd_n,
  output logic              rd_oe,
  output logic              wr_n,
  output logic              wr_oe,
  output logic [DATA_W-1:0] rdata,
  output logic              done
);
  slot_t slot, slot_nxt;
  logic accept, ev_load, ev_req_on, ev_ale_on, ev_addr, ev_ale_off;
  logic ev_data, ev_strobe, ev_capture, ev_end;

  assign phase = slot;

  xbus_phase_ctr u_ctr (.clk(clk), .rst(rst), .slot(slot), .slot_nxt(slot_nxt));

  xbus_seq_ctrl u_ctrl (
    .clk(clk), .rst(rst), .start(start), .slot(slot), .slot_nxt(slot_nxt),
    .accept(accept), .ev_load(ev_load), .ev_req_on(ev_req_on),
    .ev_ale_on(ev_ale_on), .ev_addr(ev_addr), .ev_ale_off(ev_ale_off),
    .ev_data(ev_data), .ev_strobe(ev_strobe), .ev_capture(ev_capture),
    .ev_end(ev_end)
  );

  xbus_port_drv #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_drv (
    .clk(clk), .rst(rst), .accept(accept), .dir_wr(dir_wr),
    .mode_wide(mode_wide), .addr(addr), .wdata(wdata), .lo_in(lo_in),
    .ev_load(ev_load), .ev_req_on(ev_req_on), .ev_ale_on(ev_ale_on),
    .ev_addr(ev_addr), .ev_ale_off(ev_ale_off), .ev_data(ev_data),
    .ev_strobe(ev_strobe), .ev_capture(ev_capture), .ev_end(ev_end),
    .lo_out(lo_out), .lo_oe(lo_oe), .hi_out(hi_out), .hi_oe(hi_oe),
    .ale(ale), .bus_req(bus_req), .rd_n(rd_n), .rd_oe(rd_oe),
    .wr_n(wr_n), .wr_oe(wr_oe), .rdata(rdata), .done(done)
  );
endmodule

// File: rtl/xbus_seq_chk.sv
module xbus_seq_chk
  import xbus_pkg::*;
(
  input logic        clk,
  input logic        rst,
  input logic [SLOT_W-1:0] phase,
  input logic        lo_oe,
  input logic        hi_oe,
  input logic        ale,
  input logic        bus_req,
  input logic        rd_n,
  input logic        rd_oe,
  input logic        wr_n,
  input logic        wr_oe,
  input logic        done,
  input logic        ev_capture,
  input logic        ev_end
);
  assert_slot_step_R1: assert property (@(posedge clk) disable iff (rst)
    (phase != SLOT_W'(SLOTS - 1)) |=> (phase == $past(phase) + 1'b1));
  assert_slot_wrap_R1: assert property (@(posedge clk) disable iff (rst)
    (phase == SLOT_W'(SLOTS - 1)) |=> (phase == '0));
  assert_req_rise_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_req) |-> (phase == SL_S3P1));
  assert_req_fall_R9: assert property (@(posedge clk) disable iff (rst)
    $fell(bus_req) |-> done);
  assert_ale_rise_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(ale) |-> (phase == SL_S4P2));
  assert_ale_fall_R5: assert property (@(posedge clk) disable iff (rst)
    $fell(ale) |-> (phase == SL_S5P2));
  assert_ale_in_req_R5: assert property (@(posedge clk) disable iff (rst)
    ale |-> bus_req);
  assert_rd_fall_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(rd_n) |-> (phase == SL_S1P1) && !lo_oe);
  assert_rd_window_R7: assert property (@(posedge clk) disable iff (rst)
    !rd_n |-> (phase < SL_S4P1) && bus_req);
  assert_wr_window_R8: assert property (@(posedge clk) disable iff (rst)
    !wr_n |-> (phase < SL_S4P1) && bus_req);
  assert_strobe_excl_R10: assert property (@(posedge clk) disable iff (rst)
    !(rd_oe && wr_oe));
  assert_strobe_enabled_R10: assert property (@(posedge clk) disable iff (rst)
    (!rd_n |-> rd_oe) and (!wr_n |-> wr_oe));
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  assert_done_release_R9: assert property (@(posedge clk) disable iff (rst)
    done |-> !lo_oe && !hi_oe && !rd_oe && !wr_oe && (phase == SL_S4P1));
  assert_capture_then_end_R7: assert property (@(posedge clk) disable iff (rst)
    ev_end |-> $past(ev_capture));
  assert_reset_state_R11: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> rd_n && wr_n && !ale && !bus_req && !done && !lo_oe && !hi_oe && (phase == SL_S1P1));
endmodule

bind xbus_seq xbus_seq_chk u_chk (
  .clk(clk), .rst(rst), .phase(phase), .lo_oe(lo_oe), .hi_oe(hi_oe),
  .ale(ale), .bus_req(bus_req), .rd_n(rd_n), .rd_oe(rd_oe), .wr_n(wr_n),
  .wr_oe(wr_oe), .done(done), .ev_capture(ev_capture), .ev_end(ev_end)
);

// File: tb/sim_xbus_seq.sv
module sim_xbus_seq;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0, dir_wr = 1'b0, mode_wide = 1'b0;
  logic [15:0] addr = '0;
  logic [7:0]  wdata = '0, lo_in = '0;
  logic [3:0]  phase;
  logic [7:0]  lo_out, hi_out, rdata;
  logic lo_oe, hi_oe, ale, bus_req, rd_n, rd_oe, wr_n, wr_oe, done;

  always #(CLK_PERIOD/2) clk = ~clk;

  xbus_seq u0 (
    .clk(clk), .rst(rst), .start(start), .dir_wr(dir_wr), .mode_wide(mode_wide),
    .addr(addr), .wdata(wdata), .lo_in(lo_in), .phase(phase), .lo_out(lo_out),
    .lo_oe(lo_oe), .hi_out(hi_out), .hi_oe(hi_oe), .ale(ale), .bus_req(bus_req),
    .rd_n(rd_n), .rd_oe(rd_oe), .wr_n(wr_n), .wr_oe(wr_oe), .rdata(rdata),
    .done(done)
  );

  int checks = 0, fails = 0;
  int issued = 0, req_rises = 0;
  logic prev_req = 1'b0;
  logic [7:0] cur_rv = 8'h00;

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // Behavioural reference: position counted from the first slot of an access.
  int  m_slot = 0, m_pos = 0;
  bit  m_active = 0, m_armed = 0, m_done = 0;
  bit  m_wr = 0, m_wide = 0;
  logic [15:0] m_addr = '0;
  logic [7:0]  m_wdata = '0, m_cap = '0, m_lo = '0, m_hi = '0, m_rdata = '0;
  string m_lo_tag = "R11";

  always @(posedge clk) begin
    if (rst) begin
      m_slot = 0; m_pos = 0; m_active = 0; m_armed = 0; m_done = 0;
      m_lo = '0; m_hi = '0; m_rdata = '0; m_lo_tag = "R11";
    end else begin
      bit was_idle;
      was_idle = !m_active && !m_armed;
      if (m_active && m_pos == 16) m_cap = lo_in;
      m_done = 0;
      m_slot = (m_slot + 1) % 12;
      if (m_active) begin
        m_pos++;
        if (m_pos == 8) begin
          m_lo = m_addr[7:0]; m_lo_tag = "R6";
          if (m_wide) m_hi = m_addr[15:8];
        end
        if (m_pos == 11 && m_wr) begin m_lo = m_wdata; m_lo_tag = "R8"; end
        if (m_pos == 18) begin
          m_active = 0; m_done = 1;
          if (!m_wr) m_rdata = m_cap;
        end
      end
      if (m_armed && m_slot == 0) begin
        m_armed = 0; m_active = 1; m_pos = 0; m_lo = 8'hFF; m_lo_tag = "R3";
      end
      if (was_idle && start) begin
        m_wr = dir_wr; m_wide = mode_wide; m_addr = addr; m_wdata = wdata;
        if (m_slot == 0) begin
          m_active = 1; m_pos = 0; m_lo = 8'hFF; m_lo_tag = "R3";
        end else m_armed = 1;
      end
    end
  end

  // Decoy on the input port except during C2 S3P1 of an access.
  always @(negedge clk)
    lo_in <= (m_active && m_pos == 16) ? cur_rv : ~cur_rv;

  // Compare every clock, away from the active edge.
  always @(negedge clk) begin
    if (!rst) begin
      bit a;
      int p;
      a = m_active; p = m_pos;
      chk(phase == m_slot[3:0], "R1 phase", phase, m_slot);
      chk(bus_req == (a && p >= 4 && p < 18), "R4 bus_req", bus_req, a && p >= 4 && p < 18);
      chk(ale == (a && (p == 7 || p == 8)), "R5 ale", ale, a && (p == 7 || p == 8));
      chk(lo_oe == (a && p >= 8 && (m_wr ? p < 18 : p < 12)), "R6 R7 lo_oe", lo_oe,
          a && p >= 8 && (m_wr ? p < 18 : p < 12));
      chk(lo_out == m_lo, {m_lo_tag, " lo_out"}, lo_out, m_lo);
      chk(hi_oe == (a && m_wide && p >= 8 && p < 18), "R6 hi_oe", hi_oe,
          a && m_wide && p >= 8 && p < 18);
      chk(hi_out == m_hi, "R6 hi_out", hi_out, m_hi);
      chk(rd_n == !(a && !m_wr && p >= 12 && p < 18), "R7 rd_n", rd_n,
          !(a && !m_wr && p >= 12 && p < 18));
      chk(wr_n == !(a && m_wr && p >= 12 && p < 18), "R8 wr_n", wr_n,
          !(a && m_wr && p >= 12 && p < 18));
      chk(rd_oe == (a && !m_wr && p >= 8 && p < 18), "R10 rd_oe", rd_oe,
          a && !m_wr && p >= 8 && p < 18);
      chk(wr_oe == (a && m_wr && p >= 8 && p < 18), "R10 wr_oe", wr_oe,
          a && m_wr && p >= 8 && p < 18);
      chk(done == m_done, "R9 done", done, m_done);
      chk(rdata == m_rdata, "R7 rdata", rdata, m_rdata);
      if (bus_req && !prev_req) req_rises++;
      prev_req = bus_req;
    end
  end

  task automatic access(input bit wr, input bit wide, input logic [15:0] a,
                        input logic [7:0] d, input logic [7:0] rv);
    cur_rv = rv;
    dir_wr = wr; mode_wide = wide; addr = a; wdata = d;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    issued++;
    // Scramble the operands: the block must hold its own copy.
    addr = ~a; wdata = ~d; dir_wr = ~wr; mode_wide = ~wide;
    while (!done) @(negedge clk);
    if (!wr) chk(rdata == rv, "R7 read byte", rdata, rv);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk(rd_n && wr_n && !ale && !bus_req && !lo_oe && !hi_oe && !rd_oe && !wr_oe && !done,
        "R11 reset outputs", {rd_n, wr_n, ale, bus_req}, 4'b1100);

    access(1'b0, 1'b0, 16'h003C, 8'h00, 8'hA5);
    access(1'b0, 1'b1, 16'h1234, 8'h00, 8'h5A);
    access(1'b1, 1'b0, 16'h0081, 8'h77, 8'h00);
    // Start sampled in phase 11 begins on the next clock (R2).
    while (phase != 4'd11) @(negedge clk);
    access(1'b1, 1'b1, 16'hBEEF, 8'hC3, 8'h00);
    // Back-to-back: start during the done slot is accepted (R2).
    access(1'b0, 1'b1, 16'h8001, 8'h00, 8'h3C);
    // Stray start mid-access must be ignored (R2).
    cur_rv = 8'h96;
    dir_wr = 1'b0; mode_wide = 1'b0; addr = 16'h0055; start = 1'b1;
    @(negedge clk); start = 1'b0; issued++;
    while (!(m_active && m_pos == 10)) @(negedge clk);
    dir_wr = 1'b1; mode_wide = 1'b1; addr = 16'hFFFF; wdata = 8'h11; start = 1'b1;
    @(negedge clk); start = 1'b0;
    while (!done) @(negedge clk);
    chk(rdata == 8'h96, "R7 read after stray start", rdata, 8'h96);
    repeat (40) @(negedge clk);
    chk(req_rises == issued, "R2 access count", req_rises, issued);
    chk(!bus_req && rd_n && wr_n, "R2 idle after stray start", bus_req, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired act=0 exp=1");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule